// File: doc/BRIEF.md
# Selectable Multi-Channel Input Debouncer

This block cleans up eight field-input bits that have already been thresholded into logic levels. Each bit is brought into the system clock domain by a two-stage synchronizer. It then passes through its own filter, and the filtered copy is handed to a downstream parallel-load serializer. A filtered bit takes a new level, rising or falling, only after the synchronized input has held that level without interruption for the whole selected filter time. Any earlier return to the old level throws away the partial count.

A two-bit select code picks the filter time while the block runs: a long interval, a short interval, or no filtering at all. The fourth code is treated like the long interval. A single prescaler, shared by all channels, turns the system clock into a millisecond tick. Its clocks-per-millisecond value is a parameter, so a bench can shrink it. Each channel counts ticks while its input disagrees with its filtered level. Any change of the select code clears every channel count and the prescaler, so each pending transition is timed afresh.

Top module: `dbnc_filter_bank`

## Requirements
- R1: While reset is asserted on a clock edge, every filtered output and every count clears, so `filt_out` reads all zeros after that edge.
- R2: With `dbnc_sel` = 2'b11 (bit 1 high, bit 0 high), a channel's output takes a new input level only after the input has been stable for at least 3 ms (3·CLKS_PER_MS cycles). It does so no later than 4·CLKS_PER_MS + 2 cycles after the raw input changed, and an output change only happens on a prescaler tick.
- R3: With `dbnc_sel` = 2'b10, the same rule applies with 1 ms: the change comes no earlier than CLKS_PER_MS + 3 cycles and no later than 2·CLKS_PER_MS + 2 cycles after the raw change.
- R4: With `dbnc_sel` = 2'b01 the filter is bypassed: `filt_out` equals `raw_in` delayed by exactly three clock cycles (two synchronizer stages plus the output register), so even a one-cycle pulse passes through.
- R5: The reserved code `dbnc_sel` = 2'b00 behaves exactly as the 3 ms setting.
- R6: Filtering is symmetric: falling transitions obey the same timing as rising ones. A filtered bit only ever changes to the level its synchronized input held one cycle earlier.
- R7: A pulse or train of pulses on a channel, where no single excursion lasts as long as the selected interval, leaves that channel's output unchanged, because the count clears whenever the input returns to the filtered level.
- R8: The eight channels filter independently: overlapping transitions on different channels each settle on their own schedule, and a glitch on one channel does not disturb another.
- R9: A change of `dbnc_sel` restarts all in-progress counts and the time base. No non-bypass output changes on the edge that sees the change, and a pending transition then completes exactly (N+1)·CLKS_PER_MS + 1 cycles after the new code is applied, where N is the new interval in ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | NUM_CH | Thresholded field-input bits, asynchronous to clk |
| dbnc_sel | input | 2 | Filter time select: 11 long, 10 short, 01 bypass, 00 reserved (long) |
| filt_out | output | NUM_CH | Debounced levels for the serializer's parallel inputs |

## Verification
The bound checker watches several properties on every cycle. It confirms the cleared outputs after reset and the exact three-cycle pass-through in bypass. It confirms that a filtered bit only moves to its previously synchronized level, that outside bypass an output moves only on a prescaler tick, and that no output moves on the edge where the select code changes. The length of the filter windows is different: the bench's timed scenarios are the only way to show the 3 ms and 1 ms minimum stability, the reserved code acting as 3 ms, glitch trains being rejected through counter clearing, overlapping channels staying independent, and the restart after a select change.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

    // Select encoding: bit 1 is the upper select line, bit 0 the lower one.
    typedef enum logic [1:0] {
        SEL_RSVD  = 2'b00,
        SEL_BYP   = 2'b01,
        SEL_SHORT = 2'b10,
        SEL_LONG  = 2'b11
    } dbnc_sel_e;

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] stg1;
        logic [W-1:0] stg2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stg1 = async_in;
        st_d.stg2 = st_q.stg1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sync_out = st_q.stg2;
endmodule

// File: rtl/dbnc_tick.sv
module dbnc_tick #(
    parameter int CLKS_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

    typedef struct packed {
        logic [PW-1:0] pc;
    } tick_st_t;

    tick_st_t st_d, st_q;

    assign tick = (st_q.pc == LAST);

    always_comb begin
        st_d = st_q;
        if (clear || tick) st_d.pc = '0;
        else               st_d.pc = st_q.pc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/dbnc_chan.sv
module dbnc_chan #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_bit,
    input  logic          tick,
    input  logic          bypass,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          filt
);
    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bypass) begin
            st_d.lvl = sync_bit;
            st_d.cnt = '0;
        end else if (restart || (sync_bit == st_q.lvl)) begin
            st_d.cnt = '0;
        end else if (tick) begin
            // limit ticks counted, then one more full tick period confirms
            if (st_q.cnt == limit) begin
                st_d.lvl = sync_bit;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign filt = st_q.lvl;
endmodule

// File: rtl/dbnc_filter_bank.sv
module dbnc_filter_bank
    import dbnc_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int CLKS_PER_MS = 125000,
    parameter int LONG_MS     = 3,
    parameter int SHORT_MS    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] raw_in,
    input  logic [1:0]        dbnc_sel,
    output logic [NUM_CH-1:0] filt_out
);
    localparam int MAX_MS = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
    localparam int CW     = (MAX_MS > 0) ? $clog2(MAX_MS + 1) : 1;

    typedef struct packed {
        logic [1:0] sel;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_CH-1:0] sync_w;
    logic              tick_w;
    logic              restart_w;
    logic              bypass_w;
    logic [CW-1:0]     limit_w;
    logic [1:0]        sel_hold;

    assign sel_hold = st_q.sel;

    always_comb begin
        st_d      = st_q;
        st_d.sel  = dbnc_sel;
        restart_w = (dbnc_sel != st_q.sel);
        bypass_w  = 1'b0;
        limit_w   = CW'(LONG_MS);
        case (dbnc_sel_e'(dbnc_sel))
            SEL_BYP:   bypass_w = 1'b1;
            SEL_SHORT: limit_w  = CW'(SHORT_MS);
            default:   limit_w  = CW'(LONG_MS);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.sel <= dbnc_sel;
        else     st_q     <= st_d;
    end

    dbnc_sync #(.W(NUM_CH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_in),
        .sync_out (sync_w)
    );

    dbnc_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clear (restart_w),
        .tick  (tick_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dbnc_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .sync_bit (sync_w[g]),
            .tick     (tick_w),
            .bypass   (bypass_w),
            .restart  (restart_w),
            .limit    (limit_w),
            .filt     (filt_out[g])
        );
    end
endmodule

// File: rtl/dbnc_chk.sv
module dbnc_chk
    import dbnc_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] din,
    input logic [1:0]        sel,
    input logic [NUM_CH-1:0] dout,
    input logic [NUM_CH-1:0] sync,
    input logic              tick,
    input logic [1:0]        sel_q
);
    logic [2:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)                  since_q <= '0;
        else if (since_q != 3'd7) since_q <= since_q + 3'd1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (dout == '0));

    // R4
    bypass_delay_chk: assert property (@(posedge clk) disable iff (rst)
        ((since_q >= 3'd4) && ($past(sel) == 2'(SEL_BYP))) |-> (dout == $past(din, 3)));

    // R6
    moves_to_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 3'd1) |-> (((dout ^ $past(dout)) & (dout ^ $past(sync))) == '0));

    // R2
    change_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ((since_q >= 3'd2) && ($past(sel) != 2'(SEL_BYP)) && (dout != $past(dout))) |-> $past(tick));

    // R9
    sel_change_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((since_q >= 3'd1) && (sel != sel_q) && (sel != 2'(SEL_BYP))) |=> $stable(dout));
endmodule

bind dbnc_filter_bank dbnc_chk #(.NUM_CH(NUM_CH)) u_dbnc_chk (
    .clk   (clk),
    .rst   (rst),
    .din   (raw_in),
    .sel   (dbnc_sel),
    .dout  (filt_out),
    .sync  (sync_w),
    .tick  (tick_w),
    .sel_q (sel_hold)
);

// File: tb/tb_dbnc_filter_bank.sv
module tb_dbnc_filter_bank;
    localparam int NCH = 8;
    localparam int P   = 20;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] raw_in = '0;
    logic [1:0]     dbnc_sel = 2'b11;
    logic [NCH-1:0] filt_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [NCH-1:0] mdl  = '0;
    logic [NCH-1:0] prev = '0;

    typedef struct {
        int    ch;
        bit    val;
        int    lo;
        int    hi;
        string req;
    } exp_t;

    exp_t exp_q[$];

    dbnc_filter_bank #(.NUM_CH(NCH), .CLKS_PER_MS(P), .LONG_MS(3), .SHORT_MS(1)) dut (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (raw_in),
        .dbnc_sel (dbnc_sel),
        .filt_out (filt_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver side: record an expected output edge with a latency window
    task automatic expect_edge(input int ch, input bit val, input int lo_lat,
                               input int hi_lat, input string req);
        exp_t e;
        e.ch = ch; e.val = val; e.lo = cyc + lo_lat; e.hi = cyc + hi_lat; e.req = req;
        exp_q.push_back(e);
        mdl[ch] = val;
    endtask

    task automatic settle(input int n, input string req);
        repeat (n) @(negedge clk);
        chk(exp_q.size() == 0, req, "missing expected edges", exp_q.size(), 0);
        chk(filt_out == mdl, req, "settled output", filt_out, mdl);
    endtask

    // monitor: pops expectations as output edges appear
    always @(negedge clk) begin
        if (rst) begin
            prev <= filt_out;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (filt_out[c] !== prev[c]) begin
                    int idx = -1;
                    for (int k = 0; k < exp_q.size(); k++)
                        if (idx < 0 && exp_q[k].ch == c && exp_q[k].val == filt_out[c]) idx = k;
                    if (idx < 0) begin
                        chk(1'b0, "R7", $sformatf("unexpected edge ch%0d", c), filt_out[c], prev[c]);
                    end else begin
                        chk(cyc >= exp_q[idx].lo && cyc <= exp_q[idx].hi, exp_q[idx].req,
                            $sformatf("edge time ch%0d (window %0d..%0d)", c, exp_q[idx].lo, exp_q[idx].hi),
                            cyc, exp_q[idx].lo);
                        exp_q.delete(idx);
                    end
                end
            end
            prev <= filt_out;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset
        repeat (5) @(negedge clk);
        chk(filt_out == '0, "R1", "output under reset", filt_out, 0);
        rst = 1'b0;
        settle(4, "R1");

        // R2 rising edge, 3 ms
        raw_in[0] = 1'b1;
        expect_edge(0, 1'b1, 3*P + 3, 4*P + 2, "R2");
        settle(5*P, "R2");

        // R6 falling edge, same timing
        raw_in[0] = 1'b0;
        expect_edge(0, 1'b0, 3*P + 3, 4*P + 2, "R6");
        settle(5*P, "R6");

        // R3 short interval
        dbnc_sel = 2'b10;
        settle(5, "R3");
        raw_in[1] = 1'b1;
        expect_edge(1, 1'b1, P + 3, 2*P + 2, "R3");
        settle(3*P, "R3");

        // R8 overlapping channels plus a glitch on a third
        raw_in[2] = 1'b1;
        expect_edge(2, 1'b1, P + 3, 2*P + 2, "R8");
        repeat (5) @(negedge clk);
        raw_in[3] = 1'b1;
        expect_edge(3, 1'b1, P + 3, 2*P + 2, "R8");
        raw_in[5] = 1'b1;
        repeat (P - 2) @(negedge clk);
        raw_in[5] = 1'b0;
        settle(3*P, "R8");

        // R7 glitch train on channel 1 (filtered high) never commits
        for (int k = 0; k < 4; k++) begin
            raw_in[1] = 1'b0;
            repeat (P - 2) @(negedge clk);
            raw_in[1] = 1'b1;
            repeat (2) @(negedge clk);
        end
        settle(3*P, "R7");

        // R4 bypass: fixed three-cycle delay, single-cycle pulse passes
        dbnc_sel = 2'b01;
        settle(5, "R4");
        raw_in[6] = 1'b1;
        expect_edge(6, 1'b1, 3, 3, "R4");
        settle(6, "R4");
        raw_in[7] = 1'b1;
        expect_edge(7, 1'b1, 3, 3, "R4");
        @(negedge clk);
        raw_in[7] = 1'b0;
        expect_edge(7, 1'b0, 3, 3, "R4");
        settle(6, "R4");

        // R5 reserved code acts as 3 ms
        dbnc_sel = 2'b00;
        settle(5, "R5");
        raw_in[4] = 1'b1;
        expect_edge(4, 1'b1, 3*P + 3, 4*P + 2, "R5");
        settle(5*P, "R5");

        // R9 select change restarts a pending count
        dbnc_sel = 2'b11;
        settle(5, "R9");
        raw_in[5] = 1'b1;
        repeat (2*P + P/2) @(negedge clk);
        dbnc_sel = 2'b00;
        expect_edge(5, 1'b1, 4*P + 1, 4*P + 1, "R9");
        settle(5*P, "R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule